// File: doc/BRIEF.md
# Keypad and Call-Progress Tone Synthesizer

This block synthesizes digital tone samples for a voice-band terminal. It produces one signed linear sample for each 8 kHz frame strobe. The block has two modes. In dual-tone mode it sums a row frequency and a column frequency. In the other mode it plays a single frequency, or a warble that swaps between two frequencies at an 8 Hz rate. The sample is meant to be added by a later stage into the transmit or the receive voice path. Gain stages and path routing sit outside this block.

Each component comes from a phase accumulator. The accumulator advances once per frame strobe and addresses a quarter-wave sine table. The table is computed at elaboration. In dual-tone mode the row component is scaled to about 2 dB below the column component. A single tone and a warble tone play at the column level. Turning the generator off, or changing the tone selection, restarts every accumulator at zero phase. Each tone burst therefore begins at a zero crossing.

Top module: `tone_gen`

## Requirements
- R1: Out of reset, `sample_out` is 0 and `sample_valid` is low.
- R2: `sample_valid` is high in exactly the clock cycle after each `sample_tick`, and low in every other cycle.
- R3: While `tone_on` is low, every strobe yields a sample of 0.
- R4: With `dtmf_sel` = 1, `tone_code[3:2]` picks the row frequency: 00 = 697 Hz, 01 = 770 Hz, 10 = 852 Hz, 11 = 941 Hz.
- R5: With `dtmf_sel` = 1, `tone_code[1:0]` picks the column frequency: 00 = 1209 Hz, 01 = 1336 Hz, 10 = 1477 Hz, 11 = 1633 Hz. `tone_code[4]` has no effect on the frequencies.
- R6: With `dtmf_sel` = 0, codes 0 to 15 give single tones at the full level. The frequencies are 400, 440, 480, 667, 800, 1000, 1200, 1300, 1477, 1633, 2000, 2100, 2400, 2500, 2700 and 3000 Hz, in code order.
- R7: With `dtmf_sel` = 0, codes 16, 17 and 18 are warbles of 2730/2500 Hz, 2000/2667 Hz and 1000/1333 Hz. The first frequency plays for 500 strobes, then the second for 500 strobes, and so on. The phase stays continuous at each swap.
- R8: In dual-tone mode the row component has amplitude AMP·51/64 and the column component has amplitude AMP. The difference is about 2 dB.
- R9: Changing `dtmf_sel` or `tone_code`, or a low `tone_on`, resets all phases to zero. The first sample after a restart is taken at zero phase.
- R10: With `dtmf_sel` = 0, codes 19 to 31 produce silence (samples of 0).
- R11: `sample_out` changes only in the cycle after a strobe and holds its value between strobes.
- R12: Each phase advances per strobe by round(f·2^PW/8000). Each component equals amplitude·sin(2π·phase/2^PW), within the quantization error of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle frame strobe at the 8 kHz sample rate |
| tone_on | input | 1 | Generator enable |
| dtmf_sel | input | 1 | 1 = dual-tone keypad mode, 0 = single/warble tones |
| tone_code | input | 5 | Tone selection code |
| sample_out | output | W (16) | Signed two's complement tone sample |
| sample_valid | output | 1 | Pulses with each new sample |

## Verification
The assertions assume that `sample_tick` is a single-cycle pulse. They also assume that the tone configuration is steady for at least one clock before the first strobe of a burst. This matters because a restart is recognised in the cycle in which the configuration differs from the latched copy. The stimulus changes `tone_on`, `dtmf_sel` and `tone_code` only on falling clock edges. It always leaves one idle clock before the next strobe. Strobes are spaced three clocks apart, so a sample can be read and a held value compared before the next strobe arrives. The random phase draws its codes over all 32 values in both modes, which includes the silent codes.

// File: rtl/tone_pkg.sv
package tone_pkg;

   localparam int unsigned FS_HZ = 8000;

   typedef struct packed {
      logic       dtmf;
      logic [4:0] code;
   } tone_cfg_t;

   // Per-sample phase step for a tone of freq_hz with a pw-bit accumulator, rounded
   function automatic int unsigned phase_inc(input int unsigned freq_hz, input int unsigned pw);
      longint unsigned num;
      num = longint'(freq_hz);
      num = (num << pw) + longint'(FS_HZ / 2);
      return 32'(num / longint'(FS_HZ));
   endfunction

endpackage

// File: rtl/tone_decode.sv
module tone_decode
   import tone_pkg::*;
#(
   parameter int PW = 16
) (
   input  tone_cfg_t       cfg,
   output logic [PW-1:0]   inc_lo,
   output logic [PW-1:0]   inc_hi,
   output logic [PW-1:0]   inc_alt,
   output logic            lo_en,
   output logic            hi_en,
   output logic            warble
);

   always_comb begin
      inc_lo  = '0;
      inc_hi  = '0;
      inc_alt = '0;
      lo_en   = 1'b0;
      hi_en   = 1'b0;
      warble  = 1'b0;
      if (cfg.dtmf) begin
         lo_en = 1'b1;
         hi_en = 1'b1;
         case (cfg.code[3:2])                       // row group (R4)
            2'd0:    inc_lo = PW'(phase_inc(697, PW));
            2'd1:    inc_lo = PW'(phase_inc(770, PW));
            2'd2:    inc_lo = PW'(phase_inc(852, PW));
            default: inc_lo = PW'(phase_inc(941, PW));
         endcase
         case (cfg.code[1:0])                       // column group (R5)
            2'd0:    inc_hi = PW'(phase_inc(1209, PW));
            2'd1:    inc_hi = PW'(phase_inc(1336, PW));
            2'd2:    inc_hi = PW'(phase_inc(1477, PW));
            default: inc_hi = PW'(phase_inc(1633, PW));
         endcase
      end else begin
         hi_en = 1'b1;
         case (cfg.code)
            5'd0:  inc_hi = PW'(phase_inc(400, PW));
            5'd1:  inc_hi = PW'(phase_inc(440, PW));
            5'd2:  inc_hi = PW'(phase_inc(480, PW));
            5'd3:  inc_hi = PW'(phase_inc(667, PW));
            5'd4:  inc_hi = PW'(phase_inc(800, PW));
            5'd5:  inc_hi = PW'(phase_inc(1000, PW));
            5'd6:  inc_hi = PW'(phase_inc(1200, PW));
            5'd7:  inc_hi = PW'(phase_inc(1300, PW));
            5'd8:  inc_hi = PW'(phase_inc(1477, PW));
            5'd9:  inc_hi = PW'(phase_inc(1633, PW));
            5'd10: inc_hi = PW'(phase_inc(2000, PW));
            5'd11: inc_hi = PW'(phase_inc(2100, PW));
            5'd12: inc_hi = PW'(phase_inc(2400, PW));
            5'd13: inc_hi = PW'(phase_inc(2500, PW));
            5'd14: inc_hi = PW'(phase_inc(2700, PW));
            5'd15: inc_hi = PW'(phase_inc(3000, PW));
            5'd16: begin
               warble  = 1'b1;
               inc_hi  = PW'(phase_inc(2730, PW));
               inc_alt = PW'(phase_inc(2500, PW));
            end
            5'd17: begin
               warble  = 1'b1;
               inc_hi  = PW'(phase_inc(2000, PW));
               inc_alt = PW'(phase_inc(2667, PW));
            end
            5'd18: begin
               warble  = 1'b1;
               inc_hi  = PW'(phase_inc(1000, PW));
               inc_alt = PW'(phase_inc(1333, PW));
            end
            default: hi_en = 1'b0;                  // silent codes (R10)
         endcase
      end
   end

endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [PW-1:0] inc,
   output logic [PW-1:0] ph
);

   logic [PW-1:0] ph_q;
   logic [PW-1:0] base;

   assign base = clr ? '0 : ph_q;
   assign ph   = base;

   always_ff @(posedge clk) begin
      if (!rst_n)   ph_q <= '0;
      else if (adv) ph_q <= base + inc;
      else          ph_q <= base;
   end

   // R9: a restart with no strobe leaves the accumulator parked at zero phase
   p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !adv) |=> (ph_q == '0));

endmodule

// File: rtl/tone_sine.sv
module tone_sine #(
   parameter int PW       = 16,
   parameter int LUT_BITS = 6,
   parameter int W        = 16,
   parameter int AMP      = 8000
) (
   input  logic [PW-1:0]        ph,
   output logic signed [W-1:0]  val
);

   localparam int Q = 2 ** LUT_BITS;

   if (PW < LUT_BITS + 2) begin : g_bad_pw
      $error("tone_sine: PW must be at least LUT_BITS+2");
   end
   if (AMP >= 2 ** (W - 1)) begin : g_bad_amp
      $error("tone_sine: AMP does not fit in W bits");
   end

   // Rational sine approximation at the centre of each quarter-wave step
   function automatic int qw_amp(input int i);
      longint u, h, p, den;
      u   = longint'(2 * i + 1);
      h   = longint'(4 * Q);
      p   = u * (h - u);
      den = 5 * h * h - 4 * p;
      return int'((16 * p * longint'(AMP) + den / 2) / den);
   endfunction

   logic [W-2:0] tab [Q];

   for (genvar i = 0; i < Q; i++) begin : g_tab
      localparam int TV = qw_amp(i);
      assign tab[i] = (W-1)'(TV);
   end

   logic [1:0]          quad;
   logic [LUT_BITS-1:0] idx;
   logic [LUT_BITS-1:0] midx;
   logic [W-2:0]        mag;

   assign quad = ph[PW-1:PW-2];
   assign idx  = ph[PW-3 -: LUT_BITS];
   assign midx = quad[0] ? ~idx : idx;
   assign mag  = tab[midx];
   assign val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

   if (PW > LUT_BITS + 2) begin : g_fine
      logic unused_fine;
      assign unused_fine = ^ph[PW-3-LUT_BITS:0];
   end

endmodule

// File: rtl/tone_gen.sv
module tone_gen
   import tone_pkg::*;
#(
   parameter int PW          = 16,
   parameter int LUT_BITS    = 6,
   parameter int W           = 16,
   parameter int AMP         = 8000,
   parameter int LOW_NUM     = 51,
   parameter int LOW_SHIFT   = 6,
   parameter int WARBLE_HALF = 500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_tick,
   input  logic                tone_on,
   input  logic                dtmf_sel,
   input  logic [4:0]          tone_code,
   output logic signed [W-1:0] sample_out,
   output logic                sample_valid
);

   localparam int CW = $clog2(WARBLE_HALF);
   localparam int MW = W + LOW_SHIFT + 1;
   localparam int LOW_AMP = (AMP * LOW_NUM) >> LOW_SHIFT;
   localparam logic signed [W-1:0] AMP_S = W'(AMP);

   if (LOW_NUM >= 2 ** LOW_SHIFT) begin : g_bad_ratio
      $error("tone_gen: LOW_NUM must be below 2**LOW_SHIFT");
   end
   if (AMP + LOW_AMP + 2 >= 2 ** (W - 1)) begin : g_bad_sum
      $error("tone_gen: summed components overflow W bits");
   end
   if (WARBLE_HALF < 2) begin : g_bad_warble
      $error("tone_gen: WARBLE_HALF must be at least 2");
   end

   // ---------------- configuration tracking and restart ----------------
   tone_cfg_t cfg_now, cfg_q;
   logic      restart, adv;

   assign cfg_now = '{dtmf: dtmf_sel, code: tone_code};
   assign restart = !tone_on || (cfg_now != cfg_q);
   assign adv     = sample_tick && tone_on;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   logic [PW-1:0] inc_lo, inc_hi, inc_alt;
   logic          lo_en, hi_en, warble;

   tone_decode #(.PW(PW)) u_dec (
      .cfg     (cfg_now),
      .inc_lo  (inc_lo),
      .inc_hi  (inc_hi),
      .inc_alt (inc_alt),
      .lo_en   (lo_en),
      .hi_en   (hi_en),
      .warble  (warble)
   );

   // ---------------- warble half-period timer ----------------
   logic [CW-1:0] wcnt_q, wcnt_b;
   logic          alt_q, alt_b;

   assign wcnt_b = restart ? '0 : wcnt_q;
   assign alt_b  = restart ? 1'b0 : alt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         alt_q  <= 1'b0;
      end else if (adv && warble) begin
         if (wcnt_b == CW'(WARBLE_HALF - 1)) begin
            wcnt_q <= '0;
            alt_q  <= ~alt_b;
         end else begin
            wcnt_q <= wcnt_b + 1'b1;
            alt_q  <= alt_b;
         end
      end else begin
         wcnt_q <= wcnt_b;
         alt_q  <= alt_b;
      end
   end

   // ---------------- two oscillators: [0] row, [1] column/single ----------------
   logic [PW-1:0]        incs [2];
   logic [PW-1:0]        phs  [2];
   logic signed [W-1:0]  vals [2];

   assign incs[0] = inc_lo;
   assign incs[1] = (warble && alt_b) ? inc_alt : inc_hi;

   for (genvar g = 0; g < 2; g++) begin : g_osc
      tone_phase #(.PW(PW)) u_ph (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (restart),
         .adv   (adv),
         .inc   (incs[g]),
         .ph    (phs[g])
      );
      tone_sine #(.PW(PW), .LUT_BITS(LUT_BITS), .W(W), .AMP(AMP)) u_sin (
         .ph  (phs[g]),
         .val (vals[g])
      );
   end

   // ---------------- level offset and mix ----------------
   logic signed [MW-1:0] lo_prod;
   logic signed [W-1:0]  lo_scaled, lo_term, hi_term;
   logic        [W:0]    mix;

   assign lo_prod   = MW'(vals[0]) * MW'(LOW_NUM);
   assign lo_scaled = W'(lo_prod >>> LOW_SHIFT);
   assign lo_term   = lo_en ? lo_scaled : '0;
   assign hi_term   = hi_en ? vals[1] : '0;
   assign mix       = {lo_term[W-1], lo_term} + {hi_term[W-1], hi_term};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_out   <= '0;
         sample_valid <= 1'b0;
      end else begin
         sample_valid <= sample_tick;
         if (sample_tick) sample_out <= tone_on ? $signed(mix[W-1:0]) : '0;
      end
   end

   // ---------------- assertions ----------------
   p_valid_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> sample_valid);
   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> !sample_valid);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(sample_out));
   p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && !tone_on) |=> (sample_out == '0));
   p_undef_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && tone_on && !dtmf_sel && tone_code > 5'd18) |=> (sample_out == '0));
   p_wcnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q < CW'(WARBLE_HALF));
   p_sine_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (vals[1] <= AMP_S) && (vals[1] >= -AMP_S));

endmodule

// File: tb/tone_gen_tb.sv
module tone_gen_tb;

   localparam int    TOL    = 260;
   localparam real   AMP_HI = 8000.0;
   localparam real   AMP_LO = 8000.0 * 51.0 / 64.0;
   localparam real   TWO_PI = 6.283185307179586;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sample_tick = 1'b0;
   logic               tone_on = 1'b0;
   logic               dtmf_sel = 1'b0;
   logic [4:0]         tone_code = '0;
   logic signed [15:0] sample_out;
   logic               sample_valid;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  bad_valid = 0;
   int  bad_hold  = 0;
   bit  done = 1'b0;

   // bench model state
   int  b_lo = 0, b_hi = 0, b_cnt = 0;
   bit  b_alt = 1'b0;
   bit  cur_on = 1'b0, cur_dt = 1'b0;
   int  cur_code = 0;

   tone_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_tick  (sample_tick),
      .tone_on      (tone_on),
      .dtmf_sel     (dtmf_sel),
      .tone_code    (tone_code),
      .sample_out   (sample_out),
      .sample_valid (sample_valid)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   function automatic int b_inc(input int f);
      return int'((longint'(f) * 65536 + 4000) / 8000);
   endfunction

   // frequencies from R4..R7, R10
   task automatic b_decode(input bit dt, input int code, output int f_lo, output int f_hi,
                           output int f_alt, output bit lo_on, output bit hi_on, output bit warb);
      f_lo = 0; f_hi = 0; f_alt = 0; lo_on = 0; hi_on = 0; warb = 0;
      if (dt) begin
         lo_on = 1; hi_on = 1;
         case ((code >> 2) & 3)
            0: f_lo = 697;  1: f_lo = 770;  2: f_lo = 852;  default: f_lo = 941;
         endcase
         case (code & 3)
            0: f_hi = 1209; 1: f_hi = 1336; 2: f_hi = 1477; default: f_hi = 1633;
         endcase
      end else begin
         hi_on = 1;
         case (code)
            0: f_hi = 400;   1: f_hi = 440;   2: f_hi = 480;   3: f_hi = 667;
            4: f_hi = 800;   5: f_hi = 1000;  6: f_hi = 1200;  7: f_hi = 1300;
            8: f_hi = 1477;  9: f_hi = 1633;  10: f_hi = 2000; 11: f_hi = 2100;
            12: f_hi = 2400; 13: f_hi = 2500; 14: f_hi = 2700; 15: f_hi = 3000;
            16: begin warb = 1; f_hi = 2730; f_alt = 2500; end
            17: begin warb = 1; f_hi = 2000; f_alt = 2667; end
            18: begin warb = 1; f_hi = 1000; f_alt = 1333; end
            default: hi_on = 0;
         endcase
      end
   endtask

   task automatic apply(input bit on, input bit dt, input int code);
      @(negedge clk);
      tone_on   = on;
      dtmf_sel  = dt;
      tone_code = code[4:0];
      if (!on || dt != cur_dt || code != cur_code) begin
         b_lo = 0; b_hi = 0; b_cnt = 0; b_alt = 0;
      end
      cur_on = on; cur_dt = dt; cur_code = code;
      @(negedge clk);
   endtask

   task automatic tick(output int s);
      int s2;
      bit v, v2;
      @(negedge clk) sample_tick = 1'b1;
      @(negedge clk) sample_tick = 1'b0;
      s = int'(sample_out);
      v = sample_valid;
      @(negedge clk);
      v2 = sample_valid;
      s2 = int'(sample_out);
      if (v !== 1'b1 || v2 !== 1'b0) bad_valid++;
      if (s2 != s) bad_hold++;
   endtask

   task automatic run_seg(input string req, input int n, input bit chk_first);
      int f_lo, f_hi, f_alt, s, w_act, w_exp;
      bit lo_on, hi_on, warb;
      real expv, err, worst;
      b_decode(cur_dt, cur_code, f_lo, f_hi, f_alt, lo_on, hi_on, warb);
      worst = 0.0; w_act = 0; w_exp = 0;
      for (int i = 0; i < n; i++) begin
         expv = 0.0;
         if (cur_on) begin
            if (lo_on) expv += AMP_LO * $sin(TWO_PI * real'(b_lo) / 65536.0);
            if (hi_on) expv += AMP_HI * $sin(TWO_PI * real'(b_hi) / 65536.0);
            b_lo = (b_lo + b_inc(f_lo)) % 65536;
            b_hi = (b_hi + b_inc((warb && b_alt) ? f_alt : f_hi)) % 65536;
            if (warb) begin
               b_cnt++;
               if (b_cnt == 500) begin b_cnt = 0; b_alt = !b_alt; end
            end
         end
         tick(s);
         err = real'(s) - expv;
         if (err < 0.0) err = -err;
         if (i == 0 && chk_first)
            check((s <= TOL) && (s >= -TOL), "R9", "first sample after restart", s, 0);
         if (err > worst) begin
            worst = err; w_act = s; w_exp = int'(expv);
         end
      end
      check(worst <= real'(TOL), req, "worst sample vs model", w_act, w_exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int r;
      r = int'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sample_out == 0, "R1", "sample after reset", int'(sample_out), 0);
      check(sample_valid == 1'b0, "R1", "valid after reset", int'(sample_valid), 0);

      // R4 / R5 / R8: all sixteen keypad pairs
      for (int c = 0; c < 16; c++) begin
         apply(1, 1, c);
         run_seg("R4", 40, 1);
      end
      // R5: bit 4 does not change the pair
      for (int c = 16; c < 24; c++) begin
         apply(1, 1, c);
         run_seg("R5", 40, 0);
      end
      // R8: a longer pair that exercises the row level
      apply(1, 1, 15);
      run_seg("R8", 200, 1);

      // R6: single tones
      for (int c = 0; c < 16; c++) begin
         apply(1, 0, c);
         run_seg("R6", 60, 1);
      end

      // R7: warbles across two swaps
      for (int c = 16; c < 19; c++) begin
         apply(1, 0, c);
         run_seg("R7", 1100, 1);
      end

      // R10: undefined other-tone codes
      for (int c = 19; c < 32; c++) begin
         apply(1, 0, c);
         run_seg("R10", 8, 0);
      end

      // R3: disabled generator, then R9 re-enable and mid-tone code change
      apply(1, 1, 5);
      run_seg("R12", 37, 1);
      apply(0, 1, 5);
      run_seg("R3", 12, 0);
      apply(1, 1, 5);
      run_seg("R9", 30, 1);
      apply(1, 1, 10);
      run_seg("R9", 30, 1);

      // R12: constrained random mix of codes, modes and lengths
      for (int k = 0; k < 40; k++) begin
         bit dt;
         int code, n;
         dt   = bit'($urandom % 2);
         code = int'($urandom % 32);
         n    = 20 + int'($urandom % 40);
         apply(1, dt, code);
         run_seg("R12", n, 0);
      end

      check(bad_valid == 0, "R2", "valid pulse errors", bad_valid, 0);
      check(bad_hold == 0, "R11", "held sample changes", bad_hold, 0);
      finish_run();
   end

endmodule